// File: doc/BRIEF.md
# Two-Level Linear-to-Physical Address Walker

This block turns a 32-bit linear address into a physical address. It reads two 32-bit entries from memory, one after the other. The first read fetches a directory entry. Its location comes from a 20-bit directory frame register and the top ten bits of the linear address. When that entry is present, its upper 20 bits name the frame of a second-level table. A second read fetches the table entry, which is selected by the middle ten bits of the address. The upper 20 bits of that entry form the page frame. The frame is joined to the untouched 12-bit byte offset. When translation is switched off, the input address comes out unchanged after one cycle and memory is not touched.

Entry bit 0 marks an entry as present. If either entry is absent, the walk stops at once. The block then raises a fault flag together with its completion pulse and keeps the offending linear address in a register for software to inspect. Memory is reached through a simple read port: the walker raises a request and holds its address until a valid pulse returns the data word.

Top module: `xlate_walker`

## Requirements
- R1: After reset, `walk_done`, `walk_fault` and `mem_rd_req` are all 0.
- R2: With `xlate_en` = 0, a request accepted when idle gives `walk_done` = 1 in the following cycle, with `phys_addr` equal to the linear address and `walk_fault` = 0. No memory read is made.
- R3: With `xlate_en` = 1, the first read address is `{dir_frame, 12'h000} + lin[31:22]*4`.
- R4: After a present directory entry D, the second read address is `{D[31:12], 12'h000} + lin[21:12]*4`.
- R5: After a present table entry T is returned, `walk_done` = 1 in the next cycle, with `phys_addr` = `{T[31:12], lin[11:0]}` and `walk_fault` = 0.
- R6: A directory entry with bit 0 = 0 ends the walk. The next cycle shows `walk_done` = 1 and `walk_fault` = 1, `fault_lin_addr` equals the linear address, and no second read is made.
- R7: A table entry with bit 0 = 0 ends the walk the same way: `walk_done` = 1 and `walk_fault` = 1 in the next cycle, with `fault_lin_addr` equal to the linear address.
- R8: `walk_done` lasts exactly one cycle per walk. `walk_fault` is never 1 while `walk_done` is 0.
- R9: A request that arrives while a walk is in progress is ignored. It changes neither that walk's result nor its read addresses, and it starts no further walk.
- R10: `mem_rd_req` and `mem_rd_addr` stay constant until `mem_rd_valid` is seen. A `mem_rd_valid` pulse while idle has no effect.
- R11: `fault_lin_addr` keeps its value through walks that complete without a fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a translation (taken only when idle) |
| req_lin_addr | input | 32 | Linear address to translate |
| xlate_en | input | 1 | Translation enable; 0 passes the address through |
| dir_frame | input | 20 | Upper 20 bits of the directory location |
| mem_rd_req | output | 1 | Read request, held until answered |
| mem_rd_addr | output | 32 | Byte address of the entry being read |
| mem_rd_valid | input | 1 | Read data is valid this cycle |
| mem_rd_data | input | 32 | Entry returned by memory |
| walk_done | output | 1 | One-cycle completion pulse |
| phys_addr | output | 32 | Translated address, valid with a non-faulting done |
| walk_fault | output | 1 | Walk hit an absent entry (only with done) |
| fault_lin_addr | output | 32 | Linear address of the most recent fault |

## Verification
All results are registered. In pass-through mode the done pulse comes one cycle after the accepted request. With translation on, the first read request is visible one cycle after acceptance, and each later read request or done pulse comes one cycle after the edge that consumes `mem_rd_valid`. The bench drives inputs on falling edges and samples on the next falling edge. At each read it checks the address, waits the chosen memory latency while checking that the request stays stable, and supplies the entry. After the final read it requires done in the very next sample, then confirms at the following sample that done has dropped and no new read has started.

// File: rtl/xw_pkg.sv
package xw_pkg;
    parameter int ADDR_W      = 32;
    parameter int OFF_W       = 12;
    parameter int IDX_W       = 10;
    parameter int ENT_SHIFT   = 2;
    parameter int PRESENT_BIT = 0;

    localparam int FRAME_W = ADDR_W - OFF_W;
    localparam int TBL_LSB = OFF_W;
    localparam int DIR_LSB = OFF_W + IDX_W;

    typedef enum logic [1:0] {
        WK_IDLE = 2'd0,
        WK_DIR  = 2'd1,
        WK_TBL  = 2'd2
    } walk_state_e;

    typedef struct packed {
        walk_state_e        state;
        logic [ADDR_W-1:0]  lin;
        logic [ADDR_W-1:0]  rd_addr;
        logic [ADDR_W-1:0]  phys;
        logic               done;
        logic               fault;
        logic [ADDR_W-1:0]  fault_addr;
    } walk_regs_t;
endpackage

// File: rtl/xw_entry_addr.sv
module xw_entry_addr
    import xw_pkg::*;
(
    input  logic [FRAME_W-1:0] frame,
    input  logic [IDX_W-1:0]   idx,
    output logic [ADDR_W-1:0]  entry_addr
);
    localparam int PAD_W = ADDR_W - IDX_W - ENT_SHIFT;

    logic [ADDR_W-1:0] base_full;
    logic [ADDR_W-1:0] idx_scaled;

    // Base is the frame with a zero-filled offset; index scaled by entry size.
    assign base_full  = {frame, {OFF_W{1'b0}}};
    assign idx_scaled = {{PAD_W{1'b0}}, idx, {ENT_SHIFT{1'b0}}};
    assign entry_addr = base_full + idx_scaled;
endmodule

// File: rtl/xw_walk_ctrl.sv
module xw_walk_ctrl
    import xw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_lin_addr,
    input  logic              xlate_en,
    input  logic [ADDR_W-1:0] dir_entry_addr,
    input  logic [ADDR_W-1:0] tbl_entry_addr,
    input  logic              mem_rd_valid,
    input  logic [ADDR_W-1:0] mem_rd_data,
    output logic [ADDR_W-1:0] lin_held,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              walk_done,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              walk_fault,
    output logic [ADDR_W-1:0] fault_lin_addr
);
    localparam walk_regs_t REGS_RESET = '{
        state:      WK_IDLE,
        lin:        '0,
        rd_addr:    '0,
        phys:       '0,
        done:       1'b0,
        fault:      1'b0,
        fault_addr: '0
    };

    walk_regs_t r_d, r_q;
    logic       entry_present;

    assign entry_present = mem_rd_data[PRESENT_BIT];

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.fault = 1'b0;
        unique case (r_q.state)
            WK_IDLE: begin
                if (req_valid) begin
                    r_d.lin = req_lin_addr;
                    if (!xlate_en) begin
                        r_d.phys = req_lin_addr;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.state   = WK_DIR;
                        r_d.rd_addr = dir_entry_addr;
                    end
                end
            end
            WK_DIR: begin
                if (mem_rd_valid) begin
                    if (!entry_present) begin
                        r_d.state      = WK_IDLE;
                        r_d.done       = 1'b1;
                        r_d.fault      = 1'b1;
                        r_d.fault_addr = r_q.lin;
                    end else begin
                        r_d.state   = WK_TBL;
                        r_d.rd_addr = tbl_entry_addr;
                    end
                end
            end
            WK_TBL: begin
                if (mem_rd_valid) begin
                    r_d.state = WK_IDLE;
                    r_d.done  = 1'b1;
                    if (!entry_present) begin
                        r_d.fault      = 1'b1;
                        r_d.fault_addr = r_q.lin;
                    end else begin
                        r_d.phys = {mem_rd_data[ADDR_W-1:OFF_W], r_q.lin[OFF_W-1:0]};
                    end
                end
            end
            default: r_d.state = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= REGS_RESET;
        else        r_q <= r_d;
    end

    assign lin_held       = r_q.lin;
    assign mem_rd_req     = (r_q.state != WK_IDLE);
    assign mem_rd_addr    = r_q.rd_addr;
    assign walk_done      = r_q.done;
    assign phys_addr      = r_q.phys;
    assign walk_fault     = r_q.fault;
    assign fault_lin_addr = r_q.fault_addr;

    AST_BYPASS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == WK_IDLE && req_valid && !xlate_en) |=> (walk_done && !walk_fault && !mem_rd_req)); // R2

    AST_DIR_ABSENT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == WK_DIR && mem_rd_valid && !entry_present) |=> (walk_done && walk_fault && !mem_rd_req)); // R6

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |=> !walk_done); // R8

    AST_FAULT_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        walk_fault |-> walk_done); // R8

    AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr))); // R10

    AST_FAULT_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !walk_fault |-> $stable(fault_lin_addr)); // R11
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
    import xw_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_lin_addr,
    input  logic                xlate_en,
    input  logic [FRAME_W-1:0]  dir_frame,
    output logic                mem_rd_req,
    output logic [ADDR_W-1:0]   mem_rd_addr,
    input  logic                mem_rd_valid,
    input  logic [ADDR_W-1:0]   mem_rd_data,
    output logic                walk_done,
    output logic [ADDR_W-1:0]   phys_addr,
    output logic                walk_fault,
    output logic [ADDR_W-1:0]   fault_lin_addr
);
    logic [ADDR_W-1:0] dir_entry_addr;
    logic [ADDR_W-1:0] tbl_entry_addr;
    logic [ADDR_W-1:0] lin_held;
    logic              unused_attr_bits;

    assign unused_attr_bits = ^{mem_rd_data[OFF_W-1:0], lin_held[ADDR_W-1:DIR_LSB]};

    xw_entry_addr i_dir_addr (
        .frame      (dir_frame),
        .idx        (req_lin_addr[DIR_LSB +: IDX_W]),
        .entry_addr (dir_entry_addr)
    );

    xw_entry_addr i_tbl_addr (
        .frame      (mem_rd_data[ADDR_W-1:OFF_W]),
        .idx        (lin_held[TBL_LSB +: IDX_W]),
        .entry_addr (tbl_entry_addr)
    );

    xw_walk_ctrl i_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_lin_addr   (req_lin_addr),
        .xlate_en       (xlate_en),
        .dir_entry_addr (dir_entry_addr),
        .tbl_entry_addr (tbl_entry_addr),
        .mem_rd_valid   (mem_rd_valid),
        .mem_rd_data    (mem_rd_data),
        .lin_held       (lin_held),
        .mem_rd_req     (mem_rd_req),
        .mem_rd_addr    (mem_rd_addr),
        .walk_done      (walk_done),
        .phys_addr      (phys_addr),
        .walk_fault     (walk_fault),
        .fault_lin_addr (fault_lin_addr)
    );
endmodule

// File: tb/test_xlate_walker.sv
`timescale 1ns/1ps
module test_xlate_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_lin_addr = '0;
    logic        xlate_en = 1'b0;
    logic [19:0] dir_frame = '0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        walk_done;
    logic [31:0] phys_addr;
    logic        walk_fault;
    logic [31:0] fault_lin_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    xlate_walker i_xlate_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lin_addr(req_lin_addr),
        .xlate_en(xlate_en), .dir_frame(dir_frame), .mem_rd_req(mem_rd_req),
        .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .walk_done(walk_done), .phys_addr(phys_addr), .walk_fault(walk_fault),
        .fault_lin_addr(fault_lin_addr)
    );

    typedef struct packed {
        logic        pg;
        logic [19:0] dbase;
        logic [31:0] lin;
        logic [31:0] pde;
        logic [31:0] pte;
        logic [31:0] exp_phys;
        logic        exp_fault;
        logic [3:0]  lat;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 20'h00010, 32'h00403ABC, 32'h00025067, 32'h0ABCD003, 32'h0ABCDABC, 1'b0, 4'd0},
        '{1'b1, 20'hFFFFF, 32'hFFFFFFFF, 32'h12345001, 32'hFEDCB001, 32'hFEDCBFFF, 1'b0, 4'd3},
        '{1'b1, 20'h00100, 32'h80001234, 32'hDEADB0FE, 32'h00000000, 32'h00000000, 1'b1, 4'd1},
        '{1'b1, 20'h00200, 32'h00000000, 32'h00300001, 32'h55555FFE, 32'h00000000, 1'b1, 4'd2},
        '{1'b0, 20'h00000, 32'hCAFEF00D, 32'h00000000, 32'h00000000, 32'hCAFEF00D, 1'b0, 4'd0},
        '{1'b1, 20'h00ABC, 32'h7FC01010, 32'h00777FFF, 32'h00001001, 32'h00001010, 1'b0, 4'd0}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int          stage;
        int          guard;
        int          late_waits;
        int          exp_reads;
        logic [31:0] exp_a;
        @(negedge clk);
        req_valid    = 1'b1;
        req_lin_addr = v.lin;
        xlate_en     = v.pg;
        dir_frame    = v.dbase;
        @(negedge clk);
        req_valid  = 1'b0;
        stage      = 0;
        guard      = 0;
        late_waits = 0;
        if (!v.pg) chk(walk_done === 1'b1, "R2 done one cycle after request", {31'b0, walk_done}, 32'd1);
        while (!walk_done && guard < 100) begin
            guard++;
            if (mem_rd_req) begin
                if (stage == 0) begin
                    exp_a = {v.dbase, 12'h000} + {20'h0, v.lin[31:22], 2'b00};
                    chk(mem_rd_addr === exp_a, "R3 directory entry address", mem_rd_addr, exp_a);
                end else begin
                    exp_a = {v.pde[31:12], 12'h000} + {20'h0, v.lin[21:12], 2'b00};
                    chk(mem_rd_addr === exp_a, "R4 table entry address", mem_rd_addr, exp_a);
                end
                for (int w = 0; w < int'(v.lat); w++) begin
                    req_valid    = 1'b1;
                    req_lin_addr = ~v.lin;
                    @(negedge clk);
                    req_valid = 1'b0;
                    chk(mem_rd_req && mem_rd_addr === exp_a, "R10 read held while waiting", mem_rd_addr, exp_a);
                end
                mem_rd_valid = 1'b1;
                mem_rd_data  = (stage == 0) ? v.pde : v.pte;
                @(negedge clk);
                mem_rd_valid = 1'b0;
                stage++;
            end else begin
                if (stage > 0) late_waits++;
                @(negedge clk);
            end
        end
        exp_reads = !v.pg ? 0 : (!v.pde[0] ? 1 : 2);
        chk(walk_done === 1'b1, "R8 walk completed", {31'b0, walk_done}, 32'd1);
        chk(stage == exp_reads, v.pg ? "R6 number of reads" : "R2 no reads", stage, exp_reads);
        chk(late_waits == 0, "R5 done in cycle after last read", late_waits, 0);
        chk(walk_fault === v.exp_fault, v.exp_fault ? (stage == 1 ? "R6 fault flag" : "R7 fault flag") : "R5 no fault",
            {31'b0, walk_fault}, {31'b0, v.exp_fault});
        if (v.exp_fault)
            chk(fault_lin_addr === v.lin, stage == 1 ? "R6 fault address" : "R7 fault address", fault_lin_addr, v.lin);
        else
            chk(phys_addr === v.exp_phys, v.pg ? "R5 physical address" : "R2 pass-through address", phys_addr, v.exp_phys);
        @(negedge clk);
        chk(walk_done === 1'b0, "R8 done lasts one cycle", {31'b0, walk_done}, 32'd0);
        chk(mem_rd_req === 1'b0, "R9 no extra walk started", {31'b0, mem_rd_req}, 32'd0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(walk_done === 1'b0 && walk_fault === 1'b0 && mem_rd_req === 1'b0, "R1 reset outputs",
            {29'b0, walk_done, walk_fault, mem_rd_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(walk_done === 1'b0 && mem_rd_req === 1'b0, "R1 idle after reset",
            {30'b0, walk_done, mem_rd_req}, 32'd0);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

        // R11: the fault address from vector 3 survives the later good walks
        chk(fault_lin_addr === VECS[3].lin, "R11 fault address held", fault_lin_addr, VECS[3].lin);

        // R10: stray valid while idle has no effect
        @(negedge clk);
        mem_rd_valid = 1'b1;
        mem_rd_data  = 32'hFFFFF000;
        @(negedge clk);
        @(negedge clk);
        mem_rd_valid = 1'b0;
        chk(walk_done === 1'b0 && mem_rd_req === 1'b0, "R10 stray valid ignored",
            {30'b0, walk_done, mem_rd_req}, 32'd0);
        chk(phys_addr === VECS[5].exp_phys, "R10 result unchanged by stray valid", phys_addr, VECS[5].exp_phys);

        // Back-to-back bypass requests
        run_vec('{1'b0, 20'h0, 32'h00000FFF, 32'h0, 32'h0, 32'h00000FFF, 1'b0, 4'd0});
        run_vec(VECS[0]);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule